// File: doc/BRIEF.md
# Multiplier-free bit-plane dot-product accumulator

The block takes two vectors of eight 8-bit integers and adds their dot product into a running 32-bit accumulator, without any multiplier. Each operand vector is viewed as an 8x8 bit matrix, with one row per element and one column per bit position. For every element, each bit of the A value is ANDed with each bit of the matching B value. The one-bit products are grouped by their combined weight i+j into 15 lanes, numbered 0 to 14. Each lane counts its set products, the count is shifted left by the lane weight, and the shifted counts are summed into the accumulator.

A vector is accepted in every cycle in which `in_valid` is high. The block keeps no queue and has no back-pressure, so it never stalls the source and never holds a result back. Each accepted vector produces a one-cycle `out_valid` pulse, and `out_result` shows the new accumulator value at that pulse. `acc_clear` starts a new sum. When it arrives with a vector, that vector's product becomes the whole sum. When it arrives alone, the accumulator is zeroed. A parameter selects between unsigned operands, which is the default, and two's-complement operands. The accumulator saturates and never wraps.

Top module: `bitplane_mac`

## Requirements
- R1: With the default unsigned setting, each accepted vector adds the sum over n = 0..7 of a[n]*b[n] to the accumulator. Element n occupies bits [8n+7:8n] of both `a_vec` and `b_vec`, and element n of A is paired only with element n of B.
- R2: If `in_valid` is sampled high at clock edge t, `out_valid` is high for exactly one cycle after edge t+1, and `out_result` then holds the updated sum. Vectors may be accepted on consecutive cycles.
- R3: A cycle with `in_valid` low produces no `out_valid` pulse. Its `a_vec` and `b_vec` values have no effect on `out_result`.
- R4: A vector accepted together with `acc_clear` high makes `out_result` equal to that vector's dot product alone.
- R5: `acc_clear` high with `in_valid` low sets `out_result` to 0 after the second following edge, and raises no `out_valid`.
- R6: In unsigned mode the accumulator saturates at 2^32-1. Further vectors leave it there until a clear.
- R7: With SIGNED_OPS=1, the operand bytes are two's complement. Bit 7 carries weight -128, so bit products in which exactly one of the two bits is bit 7 are subtracted. The accumulator is a signed 32-bit value.
- R8: In signed mode the accumulator saturates at 2^31-1 going up and at -2^31 going down.
- R9: After reset, `out_result` is 0 and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The operand vectors are valid and are accepted this cycle |
| a_vec | input | 64 | Eight A elements; element n is in bits [8n+7:8n] |
| b_vec | input | 64 | Eight B elements, laid out like `a_vec` |
| acc_clear | input | 1 | Start a new sum; travels with the vector accepted in the same cycle |
| out_valid | output | 1 | One-cycle pulse for each accepted vector |
| out_result | output | 32 | Accumulator value; unsigned or two's complement depending on the mode |

## Verification
The bench streams saturating vectors until the accumulator reaches its ceiling. A design that wraps would show a small value instead of 2^32-1 or 2^31-1. It also drives 0x80 against 0x7F toward the negative floor, which catches a wrong bit-7 sign. It pairs a nonzero A element with a zero B element in the same position and other elements elsewhere. A design that crosses elements, or mixes up the bit-to-lane mapping, then returns a nonzero or wrong sum. It mixes clears with and without vectors, and changes operands while `in_valid` is low. A design that misaligns the clear with its vector, or latches idle operands, then reports a wrong sum or a stray `out_valid` pulse.

// File: rtl/bpmac_pkg.sv
package bpmac_pkg;
  // width of a lane counter able to hold every one-bit product of one lane
  function automatic int lane_cnt_w(input int elems, input int width);
    return $clog2(elems * width + 1);
  endfunction

  function automatic int lane_count(input int width);
    return 2 * width - 1;
  endfunction
endpackage

// File: rtl/bpmac_lane.sv
// One weight lane: counts the AND products of all bit pairs (i, j) with i+j == WEIGHT.
module bpmac_lane #(
  parameter int ELEMS      = 8,
  parameter int WIDTH      = 8,
  parameter int WEIGHT     = 0,
  parameter int SIGNED_OPS = 0,
  parameter int CNT_W      = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [ELEMS*WIDTH-1:0] a_vec,
  input  logic [ELEMS*WIDTH-1:0] b_vec,
  output logic [CNT_W-1:0]       pos_cnt,
  output logic [CNT_W-1:0]       neg_cnt
);
  logic [CNT_W-1:0] pos_nx, neg_nx;

  always_comb begin
    pos_nx = '0;
    neg_nx = '0;
    for (int n = 0; n < ELEMS; n++) begin
      for (int i = 0; i < WIDTH; i++) begin
        if ((WEIGHT - i) >= 0 && (WEIGHT - i) < WIDTH) begin
          if (a_vec[n*WIDTH + i] && b_vec[n*WIDTH + WEIGHT - i]) begin
            // exactly one sign bit in the pair -> negative weight
            if (SIGNED_OPS != 0 && ((i == WIDTH - 1) != ((WEIGHT - i) == WIDTH - 1)))
              neg_nx = neg_nx + 1'b1;
            else
              pos_nx = pos_nx + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_cnt <= '0;
      neg_cnt <= '0;
    end else if (load) begin
      pos_cnt <= pos_nx;
      neg_cnt <= neg_nx;
    end
  end
endmodule

// File: rtl/bpmac_accum.sv
// Shifts each lane count by its weight, sums them and folds the sum into a saturating accumulator.
module bpmac_accum #(
  parameter int LANES      = 15,
  parameter int CNT_W      = 7,
  parameter int ACC_W      = 32,
  parameter int SIGNED_OPS = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s1_valid,
  input  logic                        s1_clear,
  input  logic [LANES-1:0][CNT_W-1:0] pos_cnt,
  input  logic [LANES-1:0][CNT_W-1:0] neg_cnt,
  output logic                        out_valid,
  output logic [ACC_W-1:0]            acc
);
  localparam int TW    = LANES + CNT_W + 2;
  localparam int EXT_W = ACC_W + 2;
  localparam logic signed [EXT_W-1:0] UMAX = {2'b00, {ACC_W{1'b1}}};
  localparam logic signed [EXT_W-1:0] SMAX = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] SMIN = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [TW-1:0]    term;
  logic signed [EXT_W-1:0] base, sum;
  logic [ACC_W-1:0]        acc_nx;

  always_comb begin
    term = '0;
    for (int s = 0; s < LANES; s++) begin
      term = term + (TW'(pos_cnt[s]) << s) - (TW'(neg_cnt[s]) << s);
    end
  end

  always_comb begin
    if (s1_clear)
      base = '0;
    else if (SIGNED_OPS != 0)
      base = {{2{acc[ACC_W-1]}}, acc};
    else
      base = {2'b00, acc};
    sum = base + {{(EXT_W-TW){term[TW-1]}}, term};
    if (SIGNED_OPS != 0) begin
      if (sum > SMAX)      acc_nx = SMAX[ACC_W-1:0];
      else if (sum < SMIN) acc_nx = SMIN[ACC_W-1:0];
      else                 acc_nx = sum[ACC_W-1:0];
    end else begin
      if (sum > UMAX)      acc_nx = UMAX[ACC_W-1:0];
      else                 acc_nx = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid)      acc <= acc_nx;
      else if (s1_clear) acc <= '0;
    end
  end
endmodule

// File: rtl/bitplane_mac.sv
module bitplane_mac #(
  parameter int ELEMS      = 8,
  parameter int WIDTH      = 8,
  parameter int ACC_W      = 32,
  parameter int SIGNED_OPS = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [ELEMS*WIDTH-1:0] a_vec,
  input  logic [ELEMS*WIDTH-1:0] b_vec,
  input  logic                   acc_clear,
  output logic                   out_valid,
  output logic [ACC_W-1:0]       out_result
);
  import bpmac_pkg::*;

  localparam int LANES = lane_count(WIDTH);
  localparam int CNT_W = lane_cnt_w(ELEMS, WIDTH);

  logic [LANES-1:0][CNT_W-1:0] pos_cnt, neg_cnt;
  logic s1_valid, s1_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_clear <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_clear <= acc_clear;
    end
  end

  for (genvar s = 0; s < LANES; s++) begin : g_lane
    bpmac_lane #(
      .ELEMS(ELEMS), .WIDTH(WIDTH), .WEIGHT(s),
      .SIGNED_OPS(SIGNED_OPS), .CNT_W(CNT_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .load(in_valid),
      .a_vec(a_vec), .b_vec(b_vec),
      .pos_cnt(pos_cnt[s]), .neg_cnt(neg_cnt[s])
    );
  end

  bpmac_accum #(
    .LANES(LANES), .CNT_W(CNT_W), .ACC_W(ACC_W), .SIGNED_OPS(SIGNED_OPS)
  ) u_accum (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_clear(s1_clear),
    .pos_cnt(pos_cnt), .neg_cnt(neg_cnt),
    .out_valid(out_valid), .acc(out_result)
  );
endmodule

// File: rtl/bitplane_mac_chk.sv
module bitplane_mac_chk #(
  parameter int ACC_W      = 32,
  parameter int SIGNED_OPS = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             acc_clear,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_result
);
  // R2
  latency_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R3
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_valid, 2) && !$past(acc_clear, 2)) |-> $stable(out_result));

  // R5
  clear_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clear && !in_valid) |=> ##1 (out_result == '0 && !out_valid));

  if (SIGNED_OPS == 0) begin : g_unsigned
    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(acc_clear, 2)) |-> (out_result >= $past(out_result)));
  end
endmodule

bind bitplane_mac bitplane_mac_chk #(.ACC_W(ACC_W), .SIGNED_OPS(SIGNED_OPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clear(acc_clear),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/bitplane_mac_tb.sv
`timescale 1ns/1ps
module bitplane_mac_tb;
  localparam longint UMAX = 64'd4294967295;
  localparam longint SMAX = 64'd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic acc_clear = 1'b0;
  logic [63:0] a_vec = '0, b_vec = '0;
  logic ov_u, ov_s;
  logic [31:0] res_u, res_s;

  int checks = 0, errors = 0;
  bit done = 0;
  longint mu = 0, ms = 0, p_mu = 0, p_ms = 0;
  bit p_v = 0;

  always #4 clk = ~clk;

  bitplane_mac u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_vec(a_vec), .b_vec(b_vec),
    .acc_clear(acc_clear), .out_valid(ov_u), .out_result(res_u));

  bitplane_mac #(.SIGNED_OPS(1)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_vec(a_vec), .b_vec(b_vec),
    .acc_clear(acc_clear), .out_valid(ov_s), .out_result(res_s));

  function automatic longint dot_u(input logic [63:0] a, input logic [63:0] b);
    longint s = 0;
    for (int n = 0; n < 8; n++) s += longint'(a[n*8 +: 8]) * longint'(b[n*8 +: 8]);
    return s;
  endfunction

  function automatic longint dot_s(input logic [63:0] a, input logic [63:0] b);
    longint s = 0;
    for (int n = 0; n < 8; n++)
      s += longint'($signed(a[n*8 +: 8])) * longint'($signed(b[n*8 +: 8]));
    return s;
  endfunction

  function automatic longint sat_u(input longint x);
    return (x > UMAX) ? UMAX : x;
  endfunction

  function automatic longint sat_s(input longint x);
    if (x > SMAX) return SMAX;
    if (x < SMIN) return SMIN;
    return x;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle at a negedge; outputs checked one negedge later reflect the previous call.
  task automatic cyc(input logic v, input logic [63:0] a, input logic [63:0] b,
                     input logic c, input bit chk, input string req);
    in_valid = v; a_vec = a; b_vec = b; acc_clear = c;
    if (v) begin
      mu = c ? dot_u(a, b) : sat_u(mu + dot_u(a, b));
      ms = c ? dot_s(a, b) : sat_s(ms + dot_s(a, b));
    end else if (c) begin
      mu = 0; ms = 0;
    end
    @(posedge clk); @(negedge clk);
    if (chk) begin
      check(req, longint'(ov_u), longint'(p_v));
      check(req, longint'(res_u), p_mu);
      check(req, longint'($signed(res_s)), p_ms);
    end
    p_v = v; p_mu = mu; p_ms = ms;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", longint'(res_u), 0);
    check("R9", longint'(ov_u), 0);
    check("R9", longint'(res_s), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 all-zero and all-ones vectors, R4 clear with vector
    cyc(1, '0, '0, 1, 1, "R4");
    cyc(1, {64{1'b1}}, {64{1'b1}}, 0, 1, "R1");
    cyc(1, {64{1'b1}}, {64{1'b1}}, 0, 1, "R1");
    cyc(0, '0, '0, 0, 1, "R1");
    // R10-style element pairing under R1: only same-index elements multiply
    cyc(1, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0705, 1, 1, "R1");
    cyc(1, 64'h0900_0000_0000_0000, 64'h0000_0000_0000_00FF, 0, 1, "R1");
    // R3 idle cycles with junk operands
    cyc(0, 64'hDEAD_BEEF_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, "R3");
    cyc(0, 64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 0, 1, "R3");
    cyc(0, '0, '0, 0, 1, "R3");
    // R5 clear without a vector
    cyc(0, {64{1'b1}}, {64{1'b1}}, 1, 1, "R5");
    cyc(0, '0, '0, 0, 1, "R5");
    cyc(0, '0, '0, 0, 1, "R5");
    // R2 back-to-back plus R7 signed corner values
    cyc(1, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 1, 1, "R7");
    cyc(1, 64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 0, 1, "R7");
    cyc(1, 64'hFF01_80FF_7F00_01FE, 64'h01FF_FF80_7F7F_FE02, 0, 1, "R2");
    cyc(0, '0, '0, 0, 1, "R2");

    // R1/R2/R7 constrained random mix
    for (int k = 0; k < 400; k++) begin
      logic v, c;
      v = ($urandom % 10) < 7;
      c = ($urandom % 12) == 0;
      cyc(v, {$urandom, $urandom}, {$urandom, $urandom}, c, 1, "R1");
    end
    cyc(0, '0, '0, 0, 1, "R2");

    // R6 unsigned saturation with all-ones vectors
    cyc(1, {64{1'b1}}, {64{1'b1}}, 1, 1, "R6");
    for (int k = 0; k < 8300; k++)
      cyc(1, {64{1'b1}}, {64{1'b1}}, 0, (k % 1024) == 0, "R6");
    cyc(0, '0, '0, 0, 1, "R6");
    check("R6", longint'(res_u), UMAX);
    cyc(1, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, 0, 1, "R6");
    cyc(0, '0, '0, 0, 1, "R6");
    check("R6", longint'(res_u), UMAX);

    // R8 signed positive saturation
    cyc(1, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 1, 1, "R8");
    for (int k = 0; k < 16400; k++)
      cyc(1, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 0, (k % 2048) == 0, "R8");
    cyc(0, '0, '0, 0, 1, "R8");
    check("R8", longint'($signed(res_s)), SMAX);

    // R8 signed negative saturation
    cyc(1, 64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 1, 1, "R8");
    for (int k = 0; k < 16600; k++)
      cyc(1, 64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 0, (k % 2048) == 0, "R8");
    cyc(0, '0, '0, 0, 1, "R8");
    check("R8", longint'($signed(res_s)), SMIN);

    // R5 clear out of saturation
    cyc(0, '0, '0, 1, 1, "R5");
    cyc(0, '0, '0, 0, 1, "R5");
    cyc(0, '0, '0, 0, 1, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule